// File: doc/BRIEF.md
# Conditional FP Move Evaluator

This block decides whether a conditional floating-point register move executes. The move can depend on one of three predicate sources. The first is one of four two-bit floating-point compare result fields in the FP status word. The second is the integer condition flags, taken from either the 32-bit or the 64-bit half of the integer condition-code byte. The third is a signed test of a 64-bit integer register value. A 2-bit source select, decoded upstream from the opcode, chooses the source. The instruction word supplies the field selector, the test code and the invert bit.

The decision is purely combinational and is valid in the same cycle as the inputs. When the decision is "skip", the block also produces the side effects of a nop. The program-counter pair advances: the new PC is the old next-PC, and the new next-PC is the old next-PC plus four. The five-bit current-exception field at the bottom of the status word is also cleared. When the decision is "take", the PC pair and the status word pass through unchanged, and a downstream unit performs the move.

Top module: `fmove_cond`

## Requirements
- R1: With source 0 (FP), instruction bits 12:11 pick the compare field. Value 0 reads status bits 11:10, and values 1, 2 and 3 read status bits 33:32, 35:34 and 37:36. A field value of 0 means equal, 1 less, 2 greater and 3 unordered.
- R2: The FP test code is instruction bits 16:14. The codes mean: 0 never; 1 field≠0; 2 field is 1 or 2; 3 field bit 0 set; 4 field==1; 5 field bit 1 set; 6 field==2; 7 field==3.
- R3: For sources 0 and 1, instruction bit 17 inverts the result of the test.
- R4: With source 1 (integer flags), the flag nibble is condition-code bits 3:0 when instruction bit 12 is 0, and bits 7:4 when it is 1. Within the nibble, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R5: The integer test code is instruction bits 16:14. The codes mean: 0 never; 1 Z; 2 Z or (N xor V); 3 N xor V; 4 C or Z; 5 C; 6 N; 7 V.
- R6: With source 2 (register), instruction bits 11:10 select the test on the signed 64-bit operand: 0 never, 1 equal to zero, 2 less than or equal to zero, 3 less than zero.
- R7: With source 2, instruction bit 12 inverts the register test result.
- R8: With source 2, when the register specifier at instruction bits 18:14 is zero, the operand reads as zero whatever the operand input carries.
- R9: When the decision is skip, pc_o equals npc_i and npc_o equals npc_i+4.
- R10: When the decision is skip, status_o bits 4:0 are zero and all other status_o bits equal status_i.
- R11: When the decision is take, pc_o, npc_o and status_o equal pc_i, npc_i and status_i.
- R12: Source select value 3 always yields skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | 2 | Predicate source: 0 FP field, 1 integer flags, 2 register, 3 none |
| insn_i | input | 32 | Instruction word |
| status_i | input | 64 | FP status word |
| ccr_i | input | 8 | Integer condition-code byte (low nibble 32-bit, high nibble 64-bit) |
| rs_val_i | input | 64 | Register operand value |
| pc_i | input | 64 | Current PC |
| npc_i | input | 64 | Current next-PC |
| take_o | output | 1 | 1 when the move executes |
| pc_o | output | 64 | Updated PC |
| npc_o | output | 64 | Updated next-PC |
| status_o | output | 64 | Updated FP status word |

## Verification
The block holds no state, so any fault in the field, nibble or test-code muxing shows up at take_o in the same cycle that the inputs are applied. Errors also reach pc_o, npc_o and status_o, because those outputs follow the decision. The bench walks every test code against every field and flag value, with and without inversion. It also drives register values at zero, ±1 and the signed extremes, and adds random traffic checked against a behavioural model on every clock. A wrong selector bit therefore shows as a mismatch on the first vector that exercises it.

// File: rtl/fmove_pkg.sv
package fmove_pkg;
  typedef enum logic [1:0] {
    SRC_FCC  = 2'd0,
    SRC_ICC  = 2'd1,
    SRC_REG  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  localparam int INSN_W       = 32;
  localparam int FSR_W        = 64;
  localparam int CCR_W        = 8;
  localparam int NUM_FCC      = 4;
  localparam int FCC_W        = 2;
  localparam int FLAG_W       = 4;
  localparam int CEXC_W       = 5;
  localparam int COND_LSB     = 14;
  localparam int COND_W       = 3;
  localparam int COND_INV_BIT = 17;
  localparam int FSEL_LSB     = 11;
  localparam int XSEL_BIT     = 12;
  localparam int RCOND_LSB    = 10;
  localparam int RINV_BIT     = 12;
  localparam int RS_LSB       = 14;
  localparam int RS_W         = 5;
  localparam int FCC0_LSB     = 10;
  localparam int FCCX_LSB     = 30;

  // bit offset of compare field k in the status word
  function automatic int fcc_lsb(int k);
    return (k == 0) ? FCC0_LSB : FCCX_LSB + 2 * k;
  endfunction
endpackage

// File: rtl/fcc_eval.sv
module fcc_eval
  import fmove_pkg::*;
(
  input  logic [NUM_FCC-1:0][FCC_W-1:0] fields_i,
  input  logic [1:0]                    fsel_i,
  input  logic [COND_W-1:0]             code_i,
  output logic                          hit_o
);
  logic [FCC_W-1:0] fcc;

  always_comb begin
    fcc = fields_i[fsel_i];
    unique case (code_i)
      3'd0: hit_o = 1'b0;
      3'd1: hit_o = (fcc != 2'd0);
      3'd2: hit_o = (fcc == 2'd1) || (fcc == 2'd2);
      3'd3: hit_o = fcc[0];
      3'd4: hit_o = (fcc == 2'd1);
      3'd5: hit_o = fcc[1];
      3'd6: hit_o = (fcc == 2'd2);
      default: hit_o = (fcc == 2'd3);
    endcase
  end
endmodule

// File: rtl/icc_eval.sv
module icc_eval
  import fmove_pkg::*;
(
  input  logic [CCR_W-1:0]  ccr_i,
  input  logic              xsel_i,
  input  logic [COND_W-1:0] code_i,
  output logic              hit_o
);
  logic [FLAG_W-1:0] fl;
  logic n_f, z_f, v_f, c_f;

  always_comb begin
    fl  = xsel_i ? ccr_i[CCR_W-1 -: FLAG_W] : ccr_i[FLAG_W-1:0];
    n_f = fl[3];
    z_f = fl[2];
    v_f = fl[1];
    c_f = fl[0];
    unique case (code_i)
      3'd0: hit_o = 1'b0;
      3'd1: hit_o = z_f;
      3'd2: hit_o = z_f | (n_f ^ v_f);
      3'd3: hit_o = n_f ^ v_f;
      3'd4: hit_o = c_f | z_f;
      3'd5: hit_o = c_f;
      3'd6: hit_o = n_f;
      default: hit_o = v_f;
    endcase
  end
endmodule

// File: rtl/reg_eval.sv
module reg_eval #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val_i,
  input  logic            rs_zero_i,
  input  logic [1:0]      rcond_i,
  input  logic            inv_i,
  output logic            hit_o
);
  logic [XLEN-1:0] opnd;
  logic is_zero, is_neg, raw;

  always_comb begin
    opnd    = rs_zero_i ? '0 : val_i;
    is_zero = (opnd == '0);
    is_neg  = opnd[XLEN-1];
    unique case (rcond_i)
      2'd0: raw = 1'b0;
      2'd1: raw = is_zero;
      2'd2: raw = is_zero | is_neg;
      default: raw = is_neg;
    endcase
    hit_o = raw ^ inv_i;
  end
endmodule

// File: rtl/pc_step.sv
module pc_step #(
  parameter int PC_W = 64,
  parameter int STEP = 4
) (
  input  logic            skip_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] npc_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  always_comb begin
    if (skip_i) begin
      pc_o  = npc_i;
      npc_o = npc_i + STEP_V;
    end else begin
      pc_o  = pc_i;
      npc_o = npc_i;
    end
  end
endmodule

// File: rtl/fmove_cond.sv
module fmove_cond
  import fmove_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PC_W = 64
) (
  input  logic [1:0]        sel_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [FSR_W-1:0]  status_i,
  input  logic [CCR_W-1:0]  ccr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   npc_i,
  output logic              take_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   npc_o,
  output logic [FSR_W-1:0]  status_o
);
  logic [NUM_FCC-1:0][FCC_W-1:0] fcc_fields;
  logic [COND_W-1:0]             code;
  logic                          fcc_hit, icc_hit, reg_hit, skip;
  logic                          unused_insn;

  assign unused_insn = ^{insn_i[INSN_W-1:RS_LSB+RS_W], insn_i[RCOND_LSB-1:0]};
  assign code        = insn_i[COND_LSB +: COND_W];

  for (genvar k = 0; k < NUM_FCC; k++) begin : g_fcc
    assign fcc_fields[k] = status_i[fcc_lsb(k) +: FCC_W];
  end

  fcc_eval u_fcc (
    .fields_i (fcc_fields),
    .fsel_i   (insn_i[FSEL_LSB +: 2]),
    .code_i   (code),
    .hit_o    (fcc_hit)
  );

  icc_eval u_icc (
    .ccr_i  (ccr_i),
    .xsel_i (insn_i[XSEL_BIT]),
    .code_i (code),
    .hit_o  (icc_hit)
  );

  reg_eval #(.XLEN(XLEN)) u_reg (
    .val_i     (rs_val_i),
    .rs_zero_i (insn_i[RS_LSB +: RS_W] == '0),
    .rcond_i   (insn_i[RCOND_LSB +: 2]),
    .inv_i     (insn_i[RINV_BIT]),
    .hit_o     (reg_hit)
  );

  always_comb begin
    unique case (src_e'(sel_i))
      SRC_FCC: take_o = fcc_hit ^ insn_i[COND_INV_BIT];
      SRC_ICC: take_o = icc_hit ^ insn_i[COND_INV_BIT];
      SRC_REG: take_o = reg_hit;
      default: take_o = 1'b0;
    endcase
  end

  assign skip = ~take_o;

  pc_step #(.PC_W(PC_W), .STEP(4)) u_pc (
    .skip_i (skip),
    .pc_i   (pc_i),
    .npc_i  (npc_i),
    .pc_o   (pc_o),
    .npc_o  (npc_o)
  );

  always_comb begin
    status_o = status_i;
    if (skip) status_o[CEXC_W-1:0] = '0;
  end
endmodule

// File: rtl/fmove_cond_chk.sv
module fmove_cond_chk
  import fmove_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int PC_W = 64
) (
  input logic [1:0]        sel_i,
  input logic [INSN_W-1:0] insn_i,
  input logic [FSR_W-1:0]  status_i,
  input logic [CCR_W-1:0]  ccr_i,
  input logic [XLEN-1:0]   rs_val_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [PC_W-1:0]   npc_i,
  input logic              take_o,
  input logic [PC_W-1:0]   pc_o,
  input logic [PC_W-1:0]   npc_o,
  input logic [FSR_W-1:0]  status_o
);
  logic unused_chk;
  assign unused_chk = ^{insn_i, ccr_i, rs_val_i};

  always_comb begin
    if (!take_o) begin
      p_skip_pc_r9: assert (pc_o == npc_i && npc_o == npc_i + PC_W'(4))
        else $error("skip pc update wrong");
      p_skip_cexc_r10: assert (status_o[CEXC_W-1:0] == '0 &&
                               status_o[FSR_W-1:CEXC_W] == status_i[FSR_W-1:CEXC_W])
        else $error("skip status wrong");
    end else begin
      p_take_pass_r11: assert (pc_o == pc_i && npc_o == npc_i && status_o == status_i)
        else $error("take passthrough wrong");
    end
    if (sel_i == 2'd3) begin
      p_none_skip_r12: assert (!take_o) else $error("source 3 took");
    end
  end
endmodule

bind fmove_cond fmove_cond_chk #(.XLEN(XLEN), .PC_W(PC_W)) u_chk (.*);

// File: tb/fmove_cond_bench.sv
module fmove_cond_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  sel;
  logic [31:0] insn;
  logic [63:0] st, rv, pc, npc;
  logic [7:0]  ccr;
  logic        take;
  logic [63:0] pc_q, npc_q, st_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fmove_cond u_fmove_cond (
    .sel_i(sel), .insn_i(insn), .status_i(st), .ccr_i(ccr), .rs_val_i(rv),
    .pc_i(pc), .npc_i(npc), .take_o(take), .pc_o(pc_q), .npc_o(npc_q),
    .status_o(st_q)
  );

  function automatic bit model_take(logic [1:0] s, logic [31:0] w, logic [63:0] f,
                                    logic [7:0] cc, logic [63:0] v);
    int fld, nib, code, shamt;
    bit r, n, z, vv, c;
    longint sv;
    code = int'(w[16:14]);
    case (s)
      2'd0: begin
        shamt = (w[12:11] == 0) ? 10 : 30 + 2 * int'(w[12:11]);
        fld = int'((f >> shamt) & 64'd3);
        case (code)
          0: r = 0;
          1: r = fld != 0;
          2: r = fld == 1 || fld == 2;
          3: r = (fld % 2) == 1;
          4: r = fld == 1;
          5: r = fld >= 2;
          6: r = fld == 2;
          default: r = fld == 3;
        endcase
        return r ^ w[17];
      end
      2'd1: begin
        nib = w[12] ? int'(cc) / 16 : int'(cc) % 16;
        n = (nib / 8) % 2 == 1; z = (nib / 4) % 2 == 1;
        vv = (nib / 2) % 2 == 1; c = nib % 2 == 1;
        case (code)
          0: r = 0;
          1: r = z;
          2: r = z || (n != vv);
          3: r = n != vv;
          4: r = c || z;
          5: r = c;
          6: r = n;
          default: r = vv;
        endcase
        return r ^ w[17];
      end
      2'd2: begin
        sv = (w[18:14] == 0) ? 64'sd0 : $signed(v);
        case (int'(w[11:10]))
          0: r = 0;
          1: r = sv == 0;
          2: r = sv <= 0;
          default: r = sv < 0;
        endcase
        return r ^ w[12];
      end
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_one(logic [1:0] s, logic [31:0] w, logic [63:0] f, logic [7:0] cc,
                         logic [63:0] v, string req);
    bit et;
    @(negedge clk);
    sel = s; insn = w; st = f; ccr = cc; rv = v;
    pc = {$urandom, $urandom}; npc = {$urandom, $urandom};
    et = model_take(s, w, f, cc, v);
    @(posedge clk); #1;
    check(take == et, req, "take", 64'(take), 64'(et));
    if (et) begin
      check(pc_q == pc && npc_q == npc && st_q == st, "R11", "passthrough pc", pc_q, pc);
    end else begin
      check(pc_q == npc && npc_q == npc + 64'd4, "R9", "skip npc", npc_q, npc + 64'd4);
      check(st_q == {st[63:5], 5'd0}, "R10", "skip status", st_q, {st[63:5], 5'd0});
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    sel = 0; insn = 0; st = 0; ccr = 0; rv = 0; pc = 0; npc = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle inputs: FP code 0 never -> skip
    @(negedge clk); pc = 64'h100; npc = 64'h104;
    @(posedge clk); #1;
    check(take == 1'b0, "R2", "idle take", 64'(take), 64'd0);
    check(npc_q == 64'h108 && pc_q == 64'h104, "R9", "idle pc", npc_q, 64'h108);

    // R1 R2 R3: every field, value and code, fill other fields with the complement
    for (int k = 0; k < 4; k++)
      for (int fv = 0; fv < 4; fv++)
        for (int cd = 0; cd < 16; cd++) begin
          logic [63:0] f;
          int sh;
          f = 64'hFFFF_FFF0_FFFF_F3FF ^ {$urandom, $urandom} & 64'hFFFF_FFC0_0000_001F;
          f[11:10] = 2'(3 - fv); f[33:32] = 2'(3 - fv); f[35:34] = 2'(3 - fv); f[37:36] = 2'(3 - fv);
          sh = (k == 0) ? 10 : 30 + 2 * k;
          f[sh +: 2] = 2'(fv);
          run_one(2'd0, {14'd0, cd[3:0], 1'b0, k[1:0], 11'd0}, f, 8'hA5, 64'd0,
                  cd >= 8 ? "R3" : "R1");
        end

    // R4 R5 R3: both nibbles, all flag values, all codes
    for (int x = 0; x < 2; x++)
      for (int fl = 0; fl < 16; fl++)
        for (int cd = 0; cd < 16; cd++) begin
          logic [7:0] cc;
          cc = x[0] ? {fl[3:0], ~fl[3:0]} : {~fl[3:0], fl[3:0]};
          run_one(2'd1, {14'd0, cd[3:0], 1'b0, x[0], 12'd0}, 64'h1F, cc, 64'd0,
                  x == 1 ? "R4" : "R5");
        end

    // R6 R7 R8: register tests over edge values, with and without specifier zero
    for (int vi = 0; vi < 6; vi++)
      for (int rc = 0; rc < 8; rc++)
        for (int rz = 0; rz < 2; rz++) begin
          logic [63:0] v;
          case (vi)
            0: v = 64'd0;
            1: v = 64'd1;
            2: v = '1;
            3: v = 64'h7FFF_FFFF_FFFF_FFFF;
            4: v = 64'h8000_0000_0000_0000;
            default: v = 64'h0000_0001_0000_0000;
          endcase
          run_one(2'd2, {13'd0, (rz != 0) ? 5'd0 : 5'd7, 1'b0, rc[2:0], 10'd0}, 64'h3FF,
                  8'h00, v, rz != 0 ? "R8" : (rc >= 4 ? "R7" : "R6"));
        end

    // R12: source 3 never takes
    for (int i = 0; i < 16; i++)
      run_one(2'd3, $urandom, {$urandom, $urandom}, 8'($urandom), {$urandom, $urandom}, "R12");

    // random traffic across all sources
    for (int i = 0; i < 2000; i++)
      run_one(2'($urandom), $urandom, {$urandom, $urandom}, 8'($urandom),
              ($urandom % 4 == 0) ? 64'd0 : {$urandom, $urandom}, "R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule